// File: doc/BRIEF.md
# Ordered Store Write Buffer

This block keeps a small pool of pending stores and decides when each one may write. It enforces the order between those stores and the loads that are in flight to the same cache line. A store arrives with its line address, its program age and a speculative flag. A speculative store only takes an entry and waits. A non-speculative store tries to commit at once. A commit is granted only when no older valid load to the same line is still outstanding. When it is refused, the entry remembers the latest such load's completion cycle and the requester is told how long to wait.

When a store takes an entry, every younger (or same-age) load to that line that is not itself waiting on a store is flagged for cancellation on the same cycle. Entries leave the pool through a rollback (no write) or when their scheduled write cycle arrives. A released entry cannot be reused until a later cycle. Every response is combinational in the cycle of the request. State changes take effect at the following clock edge. Ages compare as plain unsigned numbers: a smaller value is older.

Top module: `store_order_buffer`

## Requirements
- R1: After reset every entry is free, `cancel_o` is zero, and the first accepted store is placed in slot 0.
- R2: A speculative store is accepted into the lowest-numbered free slot with delay 0. It stays occupied (held, not writing) until a rollback or a successful commit.
- R3: A commit succeeds when no valid load on the same line has an age strictly below the store's age. The response delay is then 0 and the write is scheduled for the current cycle plus `WR_LAT`. The entry stays occupied until that cycle.
- R4: A commit is refused when at least one valid load on the same line is strictly older than the store. The returned delay is the latest completion cycle among those loads minus the current cycle. Invalid loads and loads on other lines are ignored, and a load's waiting flag does not matter here.
- R5: On the commit port, a free slot gives `cm_ok_o`=0 with delay 0 and has no effect. A slot that is already writing gives `cm_ok_o`=1 with delay 0. A held slot follows R3 and R4.
- R6: When no entry is free, a store is refused (`st_ok_o`=0). The delay is the negated distance from the current cycle to the earliest nonzero recorded completion cycle, and 0 if that cycle has been reached. The delay is −1 if every occupied entry records zero.
- R7: On an accepted store, `cancel_o` bit i is set for each valid load i on the same line whose age is greater than or equal to the store's age and whose waiting flag is low. When no store is accepted, `cancel_o` is zero.
- R8: A rollback releases a held or writing entry without a write. The slot can be allocated again later.
- R9: An entry released in cycle c, by reaching its write cycle or by rollback, cannot be allocated in cycle c. It can be allocated from cycle c+1. A store that finds the buffer full in cycle c is refused.
- R10: A rollback and a commit to the same slot in the same cycle: the rollback wins and `cm_ok_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_i | input | CYC_W | Current cycle count |
| st_req_i | input | 1 | Store allocation request |
| st_line_i | input | LINE_W | Cache-line address of the store |
| st_age_i | input | AGE_W | Program age of the store (smaller is older) |
| st_spec_i | input | 1 | Store is speculative; do not commit yet |
| st_ok_o | output | 1 | Store accepted into an entry |
| st_slot_o | output | SLOT_W | Slot given to the accepted store |
| st_delay_o | output | CYC_W+1 | Signed response delay for the store request |
| cm_req_i | input | 1 | Commit request |
| cm_slot_i | input | SLOT_W | Slot to commit |
| cm_ok_o | output | 1 | Commit granted (or already writing) |
| cm_delay_o | output | CYC_W+1 | Signed wait for a refused commit |
| rb_req_i | input | 1 | Rollback request |
| rb_slot_i | input | SLOT_W | Slot to roll back |
| ld_valid_i | input | LOADS | Load-table entry valid flags |
| ld_line_i | input | LOADS*LINE_W | Load line addresses, load i at bits i*LINE_W upward |
| ld_age_i | input | LOADS*AGE_W | Load ages, same packing |
| ld_done_i | input | LOADS*CYC_W | Load completion cycles, same packing |
| ld_wait_i | input | LOADS | Load is itself waiting on a store |
| cancel_o | output | LOADS | Loads to cancel this cycle |

## Verification
Two release-versus-allocation collisions are provoked on purpose. First, a full buffer sees a store request in the exact cycle an entry's write time arrives. Second, a rollback and a store land on the same cycle. In both cases the request must be refused in that cycle and granted the slot one cycle later. A commit and a rollback aimed at the same slot are also issued together. The result is judged by whether that slot can be allocated on the next cycle, which is only true if the rollback took precedence. A sweep over every mix of same or other line, waiting flag and older or younger age across all four loads compares the cancel mask and the refusal delay with values computed directly from the rules.

// File: rtl/swb_pkg.sv
package swb_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_HELD  = 2'd1,
        PH_WRITE = 2'd2
    } swb_phase_e;

    function automatic logic swb_is_free(input swb_phase_e ph);
        return ph == PH_IDLE;
    endfunction

endpackage

// File: rtl/swb_load_scan.sv
module swb_load_scan
#(
    parameter int LOADS  = 4,
    parameter int LINE_W = 12,
    parameter int AGE_W  = 8,
    parameter int CYC_W  = 16
)
(
    input  logic [LINE_W-1:0]             line_i,
    input  logic [AGE_W-1:0]              age_i,
    input  logic [LOADS-1:0]              ld_valid_i,
    input  logic [LOADS-1:0][LINE_W-1:0]  ld_line_i,
    input  logic [LOADS-1:0][AGE_W-1:0]   ld_age_i,
    input  logic [LOADS-1:0][CYC_W-1:0]   ld_done_i,
    input  logic [LOADS-1:0]              ld_wait_i,
    output logic                          older_hit_o,
    output logic [CYC_W-1:0]              older_done_o,
    output logic [LOADS-1:0]              kill_o
);

    logic [LOADS-1:0] same_line;
    logic [LOADS-1:0] is_older;

    for (genvar i = 0; i < LOADS; i++) begin : g_match
        assign same_line[i] = ld_valid_i[i] && (ld_line_i[i] == line_i);
        assign is_older[i]  = same_line[i] && (ld_age_i[i] < age_i);
        assign kill_o[i]    = same_line[i] && !is_older[i] && !ld_wait_i[i];
    end

    always_comb begin
        older_hit_o  = 1'b0;
        older_done_o = '0;
        for (int i = 0; i < LOADS; i++) begin
            if (is_older[i]) begin
                older_hit_o = 1'b1;
                if (ld_done_i[i] > older_done_o) begin
                    older_done_o = ld_done_i[i];
                end
            end
        end
    end

endmodule

// File: rtl/swb_pick.sv
module swb_pick
#(
    parameter int ENTRIES = 4,
    parameter int CYC_W   = 16,
    parameter int SLOT_W  = 2
)
(
    input  logic [ENTRIES-1:0]            free_i,
    input  logic [ENTRIES-1:0][CYC_W-1:0] done_i,
    output logic                          has_free_o,
    output logic [SLOT_W-1:0]             slot_o,
    output logic                          has_mark_o,
    output logic [CYC_W-1:0]              mark_o
);

    always_comb begin
        has_free_o = 1'b0;
        slot_o     = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (free_i[i]) begin
                has_free_o = 1'b1;
                slot_o     = SLOT_W'(i);
            end
        end
    end

    always_comb begin
        has_mark_o = 1'b0;
        mark_o     = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!free_i[i] && (done_i[i] != '0)) begin
                if (!has_mark_o || (done_i[i] < mark_o)) begin
                    mark_o = done_i[i];
                end
                has_mark_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/swb_entry.sv
module swb_entry
    import swb_pkg::*;
#(
    parameter int LINE_W = 12,
    parameter int AGE_W  = 8,
    parameter int CYC_W  = 16,
    parameter int WR_LAT = 6
)
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CYC_W-1:0]  cyc_i,
    input  logic              load_i,
    input  logic [LINE_W-1:0] load_line_i,
    input  logic [AGE_W-1:0]  load_age_i,
    input  swb_phase_e        load_phase_i,
    input  logic [CYC_W-1:0]  load_done_i,
    input  logic              upd_i,
    input  swb_phase_e        upd_phase_i,
    input  logic [CYC_W-1:0]  upd_done_i,
    input  logic              drop_i,
    output swb_phase_e        phase_o,
    output logic [LINE_W-1:0] line_o,
    output logic [AGE_W-1:0]  age_o,
    output logic [CYC_W-1:0]  done_o
);

    swb_phase_e        phase_q;
    logic [LINE_W-1:0] line_q;
    logic [AGE_W-1:0]  age_q;
    logic [CYC_W-1:0]  done_q;
    logic              write_over;

    assign write_over = (phase_q == PH_WRITE) && (done_q <= cyc_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            line_q  <= '0;
            age_q   <= '0;
            done_q  <= '0;
        end else if (drop_i) begin
            phase_q <= PH_IDLE;
            done_q  <= '0;
        end else if (load_i) begin
            phase_q <= load_phase_i;
            line_q  <= load_line_i;
            age_q   <= load_age_i;
            done_q  <= load_done_i;
        end else if (upd_i) begin
            phase_q <= upd_phase_i;
            done_q  <= upd_done_i;
        end else if (write_over) begin
            phase_q <= PH_IDLE;
            done_q  <= '0;
        end
    end

    assign phase_o = phase_q;
    assign line_o  = line_q;
    assign age_o   = age_q;
    assign done_o  = done_q;

    AST_ALLOC_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
        load_i |-> phase_q == PH_IDLE); // R9

    AST_WRITE_STAYS: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WRITE) && (done_q > cyc_i) && !drop_i |=> phase_q == PH_WRITE); // R3

    AST_WRITE_TIME: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WRITE) && ($past(phase_q) != PH_WRITE)
            |-> done_q == $past(cyc_i) + CYC_W'(WR_LAT)); // R3

endmodule

// File: rtl/store_order_buffer.sv
module store_order_buffer
    import swb_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int LOADS   = 4,
    parameter int LINE_W  = 12,
    parameter int AGE_W   = 8,
    parameter int CYC_W   = 16,
    parameter int WR_LAT  = 6,
    localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
)
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [CYC_W-1:0]          cyc_i,
    input  logic                      st_req_i,
    input  logic [LINE_W-1:0]         st_line_i,
    input  logic [AGE_W-1:0]          st_age_i,
    input  logic                      st_spec_i,
    output logic                      st_ok_o,
    output logic [SLOT_W-1:0]         st_slot_o,
    output logic signed [CYC_W:0]     st_delay_o,
    input  logic                      cm_req_i,
    input  logic [SLOT_W-1:0]         cm_slot_i,
    output logic                      cm_ok_o,
    output logic signed [CYC_W:0]     cm_delay_o,
    input  logic                      rb_req_i,
    input  logic [SLOT_W-1:0]         rb_slot_i,
    input  logic [LOADS-1:0]          ld_valid_i,
    input  logic [LOADS*LINE_W-1:0]   ld_line_i,
    input  logic [LOADS*AGE_W-1:0]    ld_age_i,
    input  logic [LOADS*CYC_W-1:0]    ld_done_i,
    input  logic [LOADS-1:0]          ld_wait_i,
    output logic [LOADS-1:0]          cancel_o
);

    function automatic logic [CYC_W-1:0] ahead(input logic [CYC_W-1:0] tgt,
                                               input logic [CYC_W-1:0] now);
        return (tgt > now) ? (tgt - now) : '0;
    endfunction

    // load table, unpacked to per-load fields
    logic [LOADS-1:0][LINE_W-1:0] ld_line_a;
    logic [LOADS-1:0][AGE_W-1:0]  ld_age_a;
    logic [LOADS-1:0][CYC_W-1:0]  ld_done_a;

    assign ld_line_a = ld_line_i;
    assign ld_age_a  = ld_age_i;
    assign ld_done_a = ld_done_i;

    // entry state views
    swb_phase_e                   ent_phase [ENTRIES];
    logic [LINE_W-1:0]            ent_line  [ENTRIES];
    logic [AGE_W-1:0]             ent_age   [ENTRIES];
    logic [ENTRIES-1:0][CYC_W-1:0] ent_done;
    logic [ENTRIES-1:0]           ent_free;

    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            ent_free[e] = swb_is_free(ent_phase[e]);
        end
    end

    logic [CYC_W-1:0] wr_done;
    assign wr_done = cyc_i + CYC_W'(WR_LAT);

    // free slot and earliest recorded completion
    logic              has_free;
    logic [SLOT_W-1:0] free_slot;
    logic              has_mark;
    logic [CYC_W-1:0]  mark;

    swb_pick #(
        .ENTRIES (ENTRIES),
        .CYC_W   (CYC_W),
        .SLOT_W  (SLOT_W)
    ) u_pick (
        .free_i     (ent_free),
        .done_i     (ent_done),
        .has_free_o (has_free),
        .slot_o     (free_slot),
        .has_mark_o (has_mark),
        .mark_o     (mark)
    );

    // store port: scan the load table against the new store
    logic              st_hit;
    logic [CYC_W-1:0]  st_old_done;
    logic [LOADS-1:0]  st_kill;

    swb_load_scan #(
        .LOADS  (LOADS),
        .LINE_W (LINE_W),
        .AGE_W  (AGE_W),
        .CYC_W  (CYC_W)
    ) u_scan_store (
        .line_i       (st_line_i),
        .age_i        (st_age_i),
        .ld_valid_i   (ld_valid_i),
        .ld_line_i    (ld_line_a),
        .ld_age_i     (ld_age_a),
        .ld_done_i    (ld_done_a),
        .ld_wait_i    (ld_wait_i),
        .older_hit_o  (st_hit),
        .older_done_o (st_old_done),
        .kill_o       (st_kill)
    );

    swb_phase_e       alloc_phase;
    logic [CYC_W-1:0] alloc_done;
    logic             st_neg;
    logic [CYC_W-1:0] st_mag;

    assign st_ok_o   = st_req_i && has_free;
    assign st_slot_o = free_slot;
    assign cancel_o  = st_ok_o ? st_kill : '0;

    always_comb begin
        alloc_phase = PH_HELD;
        alloc_done  = '0;
        st_neg      = 1'b0;
        st_mag      = '0;
        if (!st_req_i) begin
            st_mag = '0;
        end else if (!has_free) begin
            st_neg = 1'b1;
            st_mag = has_mark ? ahead(mark, cyc_i) : CYC_W'(1);
        end else if (st_spec_i) begin
            alloc_phase = PH_HELD;
            alloc_done  = '0;
        end else if (st_hit) begin
            alloc_phase = PH_HELD;
            alloc_done  = st_old_done;
            st_mag      = ahead(st_old_done, cyc_i);
        end else begin
            alloc_phase = PH_WRITE;
            alloc_done  = wr_done;
        end
    end

    assign st_delay_o = st_neg ? -$signed({1'b0, st_mag}) : $signed({1'b0, st_mag});

    // commit port: select the addressed entry
    swb_phase_e        sel_phase;
    logic [LINE_W-1:0] sel_line;
    logic [AGE_W-1:0]  sel_age;

    always_comb begin
        sel_phase = PH_IDLE;
        sel_line  = '0;
        sel_age   = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (SLOT_W'(e) == cm_slot_i) begin
                sel_phase = ent_phase[e];
                sel_line  = ent_line[e];
                sel_age   = ent_age[e];
            end
        end
    end

    logic              cm_hit;
    logic [CYC_W-1:0]  cm_old_done;
    logic [LOADS-1:0]  cm_kill_unused_mask;

    swb_load_scan #(
        .LOADS  (LOADS),
        .LINE_W (LINE_W),
        .AGE_W  (AGE_W),
        .CYC_W  (CYC_W)
    ) u_scan_commit (
        .line_i       (sel_line),
        .age_i        (sel_age),
        .ld_valid_i   (ld_valid_i),
        .ld_line_i    (ld_line_a),
        .ld_age_i     (ld_age_a),
        .ld_done_i    (ld_done_a),
        .ld_wait_i    (ld_wait_i),
        .older_hit_o  (cm_hit),
        .older_done_o (cm_old_done),
        .kill_o       (cm_kill_unused_mask)
    );

    logic             cm_blocked;
    logic             cm_upd;
    swb_phase_e       cm_upd_phase;
    logic [CYC_W-1:0] cm_upd_done;
    logic [CYC_W-1:0] cm_mag;

    assign cm_blocked = rb_req_i && (rb_slot_i == cm_slot_i);

    always_comb begin
        cm_ok_o      = 1'b0;
        cm_mag       = '0;
        cm_upd       = 1'b0;
        cm_upd_phase = PH_HELD;
        cm_upd_done  = '0;
        if (cm_req_i && !cm_blocked) begin
            case (sel_phase)
                PH_WRITE: begin
                    cm_ok_o = 1'b1;
                end
                PH_HELD: begin
                    cm_upd = 1'b1;
                    if (cm_hit) begin
                        cm_upd_phase = PH_HELD;
                        cm_upd_done  = cm_old_done;
                        cm_mag       = ahead(cm_old_done, cyc_i);
                    end else begin
                        cm_ok_o      = 1'b1;
                        cm_upd_phase = PH_WRITE;
                        cm_upd_done  = wr_done;
                    end
                end
                default: begin
                    cm_ok_o = 1'b0;
                end
            endcase
        end
    end

    assign cm_delay_o = $signed({1'b0, cm_mag});

    // entries
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic take_e;
        logic upd_e;
        logic drop_e;

        assign take_e = st_ok_o && (free_slot == SLOT_W'(e));
        assign upd_e  = cm_upd && (cm_slot_i == SLOT_W'(e));
        assign drop_e = rb_req_i && (rb_slot_i == SLOT_W'(e));

        swb_entry #(
            .LINE_W (LINE_W),
            .AGE_W  (AGE_W),
            .CYC_W  (CYC_W),
            .WR_LAT (WR_LAT)
        ) u_ent (
            .clk          (clk),
            .rst          (rst),
            .cyc_i        (cyc_i),
            .load_i       (take_e),
            .load_line_i  (st_line_i),
            .load_age_i   (st_age_i),
            .load_phase_i (alloc_phase),
            .load_done_i  (alloc_done),
            .upd_i        (upd_e),
            .upd_phase_i  (cm_upd_phase),
            .upd_done_i   (cm_upd_done),
            .drop_i       (drop_e),
            .phase_o      (ent_phase[e]),
            .line_o       (ent_line[e]),
            .age_o        (ent_age[e]),
            .done_o       (ent_done[e])
        );
    end

    AST_CANCEL_NEEDS_ALLOC: assert property (@(posedge clk) disable iff (rst)
        (cancel_o != '0) |-> st_ok_o); // R7

    AST_REFUSED_NOT_POSITIVE: assert property (@(posedge clk) disable iff (rst)
        st_req_i && !st_ok_o |-> st_delay_o <= 0); // R6

    AST_GRANT_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
        cm_ok_o |-> cm_delay_o == 0); // R5

    AST_ROLLBACK_WINS: assert property (@(posedge clk) disable iff (rst)
        cm_req_i && rb_req_i && (cm_slot_i == rb_slot_i) |-> !cm_ok_o); // R10

endmodule

// File: tb/store_order_buffer_bench.sv
`timescale 1ns/1ps
module store_order_buffer_bench;

    localparam int ENTRIES = 4;
    localparam int LOADS   = 4;
    localparam int LINE_W  = 12;
    localparam int AGE_W   = 8;
    localparam int CYC_W   = 16;
    localparam int WR_LAT  = 6;
    localparam int SLOT_W  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [CYC_W-1:0] cyc;
    always @(posedge clk) begin
        if (rst) cyc <= 16'd100;
        else     cyc <= cyc + 16'd1;
    end

    logic                    st_req, st_spec, st_ok;
    logic [LINE_W-1:0]       st_line;
    logic [AGE_W-1:0]        st_age;
    logic [SLOT_W-1:0]       st_slot;
    logic signed [CYC_W:0]   st_delay;
    logic                    cm_req, cm_ok;
    logic [SLOT_W-1:0]       cm_slot;
    logic signed [CYC_W:0]   cm_delay;
    logic                    rb_req;
    logic [SLOT_W-1:0]       rb_slot;
    logic [LOADS-1:0]        ld_valid, ld_wait, cancel;
    logic [LOADS*LINE_W-1:0] ld_line;
    logic [LOADS*AGE_W-1:0]  ld_age;
    logic [LOADS*CYC_W-1:0]  ld_done;

    store_order_buffer #(
        .ENTRIES (ENTRIES), .LOADS (LOADS), .LINE_W (LINE_W),
        .AGE_W (AGE_W), .CYC_W (CYC_W), .WR_LAT (WR_LAT)
    ) u_store_order_buffer (
        .clk (clk), .rst (rst), .cyc_i (cyc),
        .st_req_i (st_req), .st_line_i (st_line), .st_age_i (st_age), .st_spec_i (st_spec),
        .st_ok_o (st_ok), .st_slot_o (st_slot), .st_delay_o (st_delay),
        .cm_req_i (cm_req), .cm_slot_i (cm_slot), .cm_ok_o (cm_ok), .cm_delay_o (cm_delay),
        .rb_req_i (rb_req), .rb_slot_i (rb_slot),
        .ld_valid_i (ld_valid), .ld_line_i (ld_line), .ld_age_i (ld_age),
        .ld_done_i (ld_done), .ld_wait_i (ld_wait), .cancel_o (cancel)
    );

    int  tests = 0;
    int  fails = 0;
    bit  finished = 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clr();
        st_req = 0; st_spec = 0; st_line = '0; st_age = '0;
        cm_req = 0; cm_slot = '0; rb_req = 0; rb_slot = '0;
        ld_valid = '0; ld_wait = '0; ld_line = '0; ld_age = '0; ld_done = '0;
    endtask

    task automatic set_load(input int i, input bit v, input int line, input int age,
                            input int done, input bit w);
        ld_valid[i] = v;
        ld_wait[i]  = w;
        ld_line[i*LINE_W +: LINE_W] = LINE_W'(line);
        ld_age[i*AGE_W +: AGE_W]    = AGE_W'(age);
        ld_done[i*CYC_W +: CYC_W]   = CYC_W'(done);
    endtask

    task automatic spec_store(input int line, input int age);
        st_req = 1; st_spec = 1; st_line = LINE_W'(line); st_age = AGE_W'(age);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 120000);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int c;
        clr();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;

        // reset state and commit to a free slot
        cm_req = 1; cm_slot = 0;
        #1;
        check("R1 no grant without request", int'(st_ok), 0);
        check("R1 cancel zero after reset", int'(cancel), 0);
        check("R5 commit on free slot ok", int'(cm_ok), 0);
        check("R5 commit on free slot delay", int'(cm_delay), 0);
        step();

        // first speculative store, with cancellation mix
        clr();
        spec_store(12'h008, 10);
        set_load(0, 1, 12'h008, 20, 0, 0);
        set_load(1, 1, 12'h008, 30, 0, 1);
        set_load(2, 1, 12'h009, 30, 0, 0);
        #1;
        check("R1 first store accepted", int'(st_ok), 1);
        check("R1 first slot is zero", int'(st_slot), 0);
        check("R2 speculative delay", int'(st_delay), 0);
        check("R7 cancel mask on speculative store", int'(cancel), 1);
        step();

        for (int k = 1; k < 4; k++) begin
            clr();
            spec_store(8 + 8 * k, 10 + k);
            #1;
            check("R2 lowest free slot", int'(st_slot), k);
            check("R2 speculative delay zero", int'(st_delay), 0);
            step();
        end

        // full, every entry uncommitted
        clr();
        spec_store(12'h028, 14);
        set_load(0, 1, 12'h028, 20, 0, 0);
        #1;
        check("R6 full refuses", int'(st_ok), 0);
        check("R6 full with all uncommitted", int'(st_delay), -1);
        check("R7 no cancel when refused", int'(cancel), 0);
        step();

        // refused commit on slot 1 (line 0x010, age 11)
        clr();
        c = int'(cyc);
        cm_req = 1; cm_slot = 1;
        set_load(0, 1, 12'h010, 5, c + 9, 0);
        set_load(1, 1, 12'h010, 3, c + 4, 1);
        set_load(2, 0, 12'h010, 1, c + 50, 0);
        set_load(3, 1, 12'h011, 1, c + 40, 0);
        #1;
        check("R4 commit refused", int'(cm_ok), 0);
        check("R4 refusal delay is latest older load", int'(cm_delay), 9);
        step();

        clr();
        spec_store(12'h028, 14);
        #1;
        check("R6 full delay to recorded completion", int'(st_delay), -8);
        step();

        // successful commit at c+2 -> write done at c+8
        clr();
        cm_req = 1; cm_slot = 1;
        #1;
        check("R3 commit granted", int'(cm_ok), 1);
        check("R3 commit delay zero", int'(cm_delay), 0);
        step();

        clr();
        cm_req = 1; cm_slot = 1;
        spec_store(12'h028, 14);
        #1;
        check("R5 commit on writing slot", int'(cm_ok), 1);
        check("R6 full delay to write time", int'(st_delay), -5);
        step();

        while (int'(cyc) < c + 8) begin
            clr();
            spec_store(12'h028, 14);
            #1;
            check("R3 entry occupied until write time", int'(st_ok), 0);
            step();
        end

        clr();
        spec_store(12'h028, 14);
        #1;
        check("R9 not reusable in release cycle", int'(st_ok), 0);
        check("R9 delay zero at release cycle", int'(st_delay), 0);
        step();

        clr();
        spec_store(12'h030, 15);
        #1;
        check("R9 reusable next cycle", int'(st_ok), 1);
        check("R9 released slot chosen", int'(st_slot), 1);
        step();

        // rollback with a simultaneous store
        clr();
        rb_req = 1; rb_slot = 2;
        spec_store(12'h038, 16);
        #1;
        check("R9 rollback slot not reused same cycle", int'(st_ok), 0);
        check("R6 full delay all uncommitted", int'(st_delay), -1);
        step();

        clr();
        spec_store(12'h038, 16);
        #1;
        check("R8 rolled back slot accepted", int'(st_ok), 1);
        check("R8 rolled back slot number", int'(st_slot), 2);
        step();

        // rollback and commit on the same slot
        clr();
        rb_req = 1; rb_slot = 3;
        cm_req = 1; cm_slot = 3;
        #1;
        check("R10 commit loses to rollback", int'(cm_ok), 0);
        step();

        clr();
        spec_store(12'h040, 17);
        #1;
        check("R10 slot free after rollback", int'(st_ok), 1);
        check("R10 slot number", int'(st_slot), 3);
        step();

        // empty the buffer
        for (int s = 0; s < ENTRIES; s++) begin
            clr();
            rb_req = 1; rb_slot = SLOT_W'(s);
            step();
        end
        clr();
        step();

        // sweep over load-table mixes for a non-speculative store
        for (int p = 0; p < 4096; p++) begin
            int base;
            int exp_cancel;
            int exp_dly;
            clr();
            base = int'(cyc);
            exp_cancel = 0;
            exp_dly = 0;
            for (int i = 0; i < LOADS; i++) begin
                int k, age, done;
                bit same, w, yg;
                k    = (p >> (3 * i)) & 7;
                same = k[0];
                w    = k[1];
                yg   = k[2];
                age  = yg ? ((i % 2) ? 100 : 101 + i) : 99 - i;
                done = base + 2 + 3 * i;
                set_load(i, 1, same ? 12'h040 : 12'h041, age, done, w);
                if (same && !w && yg) exp_cancel |= (1 << i);
                if (same && !yg && (done - base > exp_dly)) exp_dly = done - base;
            end
            st_req = 1; st_spec = 0; st_line = 12'h040; st_age = 8'd100;
            #1;
            check("R3 sweep store accepted", int'(st_ok), 1);
            check("R7 sweep cancel mask", int'(cancel), exp_cancel);
            check("R4 sweep store delay", int'(st_delay), exp_dly);
            step();
            clr();
            rb_req = 1; rb_slot = 0;
            step();
        end

        clr();
        step();
        finish_run();
    end

endmodule